// File: doc/BRIEF.md
# Reverse-Boost Output Enable Sequencer

This block is the control state machine for a reverse-boost output stage, the kind that powers a USB port from a battery in on-the-go operation. When an enable request arrives and the battery is above its cutoff, the sequencer waits a selectable start delay. It then runs a soft start of programmable length and settles into a regulated run state. While in that state it reports whether the stage is in constant-voltage or constant-current regulation. All voltage and current thresholds are compared outside the block and arrive here as single-bit flags.

Faults are handled by retrying or by latching off. An output undervoltage in the run state turns the stage off for a fixed hiccup time, then the sequencer passes through a reset state and starts the sequence again, with no limit on the number of retries. A low battery turns the output off and holds the block in reset until the battery recovers. An overvoltage flag that stays high through a full deglitch window puts the block in a latched high-impedance mode, and only dropping the enable request clears it.

All timing is counted on a millisecond tick input, which carries one clock-wide pulse per millisecond. A faster tick shortens every interval in proportion.

Top module: `boost_seq_top`

## Requirements
- R1: While reset is asserted and right after it, `state_o` is 0 (idle) and `boost_en`, `ss_en`, `hiz` and `cc_flag` are all 0. State codes on `state_o`: 0 idle, 1 start delay, 2 soft start, 3 run, 4 hiccup, 5 reset, 6 high-impedance.
- R2: In idle, `en_req`=1 together with `bat_low`=0 moves the block to start delay on the next clock. Start delay ends on the clock after N ticks have been counted in it, where `dly_sel` 00/01/10/11 selects N = 0/10/100/1000.
- R3: Soft start drives `boost_en`=1 and `ss_en`=1. It moves to run on the clock after `ss_ms` ticks have been counted in it.
- R4: In run, `boost_en`=1 and `ss_en`=0, and `cc_flag` follows `cc_mode` (0 means constant voltage, 1 means constant current). Outside run, `cc_flag` is 0.
- R5: `out_uv`=1 in run moves the block to hiccup on the next clock, with `boost_en`=0. Hiccup lasts until 3000 ticks have been counted, and the block moves to the reset state on the following clock.
- R6: From the reset state, with `en_req`=1 and `bat_low`=0, the block goes to start delay on the next clock. The hiccup-and-restart cycle repeats as often as the fault recurs.
- R7: `bat_low`=1 in start delay, soft start or run moves the block to the reset state on the next clock, with `boost_en`=0. While `bat_low` stays 1, the block does not leave reset or idle.
- R8: In soft start or run, `out_ov` held high for 100 consecutive counted ticks moves the block to high-impedance on the next clock. In that state `hiz`=1 and `boost_en`=0, and the block stays there while `en_req`=1.
- R9: Any cycle with `out_ov`=0 clears the overvoltage deglitch count, so two high stretches that are each shorter than the window never trip it.
- R10: `en_req`=0 returns the block to idle on the next clock from every state.
- R11: Timers advance only in cycles where `ms_tick`=1. Without ticks, a timed state holds indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Output enable request |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| bat_low | input | 1 | Battery below cutoff flag |
| out_uv | input | 1 | Output below undervoltage threshold flag |
| out_ov | input | 1 | Output above overvoltage threshold flag |
| cc_mode | input | 1 | Regulator in constant-current mode |
| dly_sel | input | 2 | Start delay select |
| ss_ms | input | SSW | Soft-start length in ticks |
| boost_en | output | 1 | Output stage enable |
| ss_en | output | 1 | Soft-start ramp enable |
| hiz | output | 1 | High-impedance mode flag |
| cc_flag | output | 1 | Constant-current regulation report |
| state_o | output | 3 | Current sequencer state code |

## Verification
The assertions take the status flags to be synchronous to `clk` and stable across each edge. They also take `ms_tick` to be an ordinary level that any cycle may carry. The bench drives every input on the falling edge and changes `dly_sel` and `ss_ms` only at rare random moments. Undervoltage, battery and enable-drop events are drawn as sparse pulses, and overvoltage as random bursts, so that both full trips and glitches shorter than the window occur. This mix lets hiccup retries, low-battery resets and high-impedance latching all come up within the run length.

// File: rtl/boost_seq_pkg.sv
package boost_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DELAY  = 3'd1,
    ST_SOFT   = 3'd2,
    ST_RUN    = 3'd3,
    ST_HICCUP = 3'd4,
    ST_RESET  = 3'd5,
    ST_HIZ    = 3'd6
  } seq_state_e;

endpackage

// File: rtl/boost_seq_timer.sv
// Saturating millisecond counter, cleared on every state change.
module boost_seq_timer #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic [CW-1:0] cnt_q
);

  logic          cnt_en;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_en = clr || (tick && (cnt_q != {CW{1'b1}}));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/boost_seq_ovfilt.sv
// Overvoltage deglitch: counts ticks while armed, clears on any low cycle.
module boost_seq_ovfilt #(
  parameter int OV_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tick,
  output logic trip
);

  localparam int OW = $clog2(OV_MS + 1);
  localparam logic [OW-1:0] LIMIT = OW'(OV_MS);

  logic [OW-1:0] cnt_q;
  logic [OW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = !arm || (tick && (cnt_q < LIMIT));
    cnt_d  = arm ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign trip = (cnt_q >= LIMIT);

endmodule

// File: rtl/boost_seq_fsm.sv
// Sequencer state register and next-state logic.
module boost_seq_fsm
  import boost_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_req,
  input  logic       bat_low,
  input  logic       out_uv,
  input  logic       tmr_done,
  input  logic       ov_trip,
  output seq_state_e state_q,
  output logic       state_chg
);

  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!en_req) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE:   if (!bat_low) state_d = ST_DELAY;
        ST_DELAY: begin
          if (bat_low)       state_d = ST_RESET;
          else if (tmr_done) state_d = ST_SOFT;
        end
        ST_SOFT: begin
          if (bat_low)       state_d = ST_RESET;
          else if (ov_trip)  state_d = ST_HIZ;
          else if (tmr_done) state_d = ST_RUN;
        end
        ST_RUN: begin
          if (bat_low)      state_d = ST_RESET;
          else if (ov_trip) state_d = ST_HIZ;
          else if (out_uv)  state_d = ST_HICCUP;
        end
        ST_HICCUP: if (tmr_done) state_d = ST_RESET;
        ST_RESET:  if (!bat_low) state_d = ST_DELAY;
        ST_HIZ:    state_d = ST_HIZ;
        default:   state_d = ST_IDLE;
      endcase
    end
  end

  assign state_chg = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else if (state_chg) begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/boost_seq_top.sv
module boost_seq_top
  import boost_seq_pkg::*;
#(
  parameter int DLY_MS1   = 10,
  parameter int DLY_MS2   = 100,
  parameter int DLY_MS3   = 1000,
  parameter int HICCUP_MS = 3000,
  parameter int OV_MS     = 100,
  parameter int SSW       = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_req,
  input  logic           ms_tick,
  input  logic           bat_low,
  input  logic           out_uv,
  input  logic           out_ov,
  input  logic           cc_mode,
  input  logic [1:0]     dly_sel,
  input  logic [SSW-1:0] ss_ms,
  output logic           boost_en,
  output logic           ss_en,
  output logic           hiz,
  output logic           cc_flag,
  output logic [2:0]     state_o
);

  localparam int SS_MAX  = (1 << SSW) - 1;
  localparam int MAX_A   = (DLY_MS3 > HICCUP_MS) ? DLY_MS3 : HICCUP_MS;
  localparam int MAX_T   = (MAX_A > SS_MAX) ? MAX_A : SS_MAX;
  localparam int TW      = $clog2(MAX_T + 1);

  seq_state_e    state_q;
  logic          state_chg;
  logic [TW-1:0] tmr_cnt;
  logic [TW-1:0] tmr_tgt;
  logic          tmr_done;
  logic          ov_arm;
  logic          ov_trip;

  function automatic logic [TW-1:0] dly_len(input logic [1:0] sel);
    case (sel)
      2'd0:    dly_len = '0;
      2'd1:    dly_len = TW'(DLY_MS1);
      2'd2:    dly_len = TW'(DLY_MS2);
      default: dly_len = TW'(DLY_MS3);
    endcase
  endfunction

  always_comb begin
    unique case (state_q)
      ST_DELAY:  tmr_tgt = dly_len(dly_sel);
      ST_SOFT:   tmr_tgt = TW'(ss_ms);
      ST_HICCUP: tmr_tgt = TW'(HICCUP_MS);
      default:   tmr_tgt = '1;
    endcase
  end

  assign tmr_done = (tmr_cnt >= tmr_tgt);
  assign ov_arm   = out_ov && ((state_q == ST_SOFT) || (state_q == ST_RUN));

  boost_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .bat_low  (bat_low),
    .out_uv   (out_uv),
    .tmr_done (tmr_done),
    .ov_trip  (ov_trip),
    .state_q  (state_q),
    .state_chg(state_chg)
  );

  boost_seq_timer #(.CW(TW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_chg),
    .tick (ms_tick),
    .cnt_q(tmr_cnt)
  );

  boost_seq_ovfilt #(.OV_MS(OV_MS)) u_ovf (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (ov_arm),
    .tick (ms_tick),
    .trip (ov_trip)
  );

  always_comb begin
    boost_en = (state_q == ST_SOFT) || (state_q == ST_RUN);
    ss_en    = (state_q == ST_SOFT);
    hiz      = (state_q == ST_HIZ);
    cc_flag  = (state_q == ST_RUN) && cc_mode;
    state_o  = state_q;
  end

endmodule

// File: rtl/boost_seq_chk.sv
module boost_seq_chk
  import boost_seq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       en_req,
  input logic       bat_low,
  input logic       out_uv,
  input logic       out_ov,
  input logic       boost_en,
  input logic       ss_en,
  input logic       hiz,
  input logic       cc_flag,
  input logic [2:0] state,
  input logic       ov_trip
);

  logic active;
  assign active = (state == ST_DELAY) || (state == ST_SOFT) || (state == ST_RUN);

  p_en_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en_req |=> state == ST_IDLE);

  p_bat_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_req && bat_low && active |=> state == ST_RESET);

  p_uv_hiccup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    en_req && !bat_low && !ov_trip && out_uv && state == ST_RUN |=> state == ST_HICCUP);

  p_hiccup_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en_req && state == ST_HICCUP |=> state == ST_HICCUP || state == ST_RESET);

  p_ov_trip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_req && !bat_low && ov_trip && (state == ST_SOFT || state == ST_RUN) |=> state == ST_HIZ);

  p_hiz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_req && state == ST_HIZ |=> state == ST_HIZ && hiz && !boost_en);

  p_ov_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ov |=> !ov_trip);

  p_run_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_SOFT && state != ST_RUN |=> state != ST_RUN);

  p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ss_en, hiz, cc_flag}));

endmodule

bind boost_seq_top boost_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_req  (en_req),
  .bat_low (bat_low),
  .out_uv  (out_uv),
  .out_ov  (out_ov),
  .boost_en(boost_en),
  .ss_en   (ss_en),
  .hiz     (hiz),
  .cc_flag (cc_flag),
  .state   (state_o),
  .ov_trip (ov_trip)
);

// File: tb/boost_seq_top_tb.sv
module boost_seq_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int SSW = 8;
  localparam int S_IDLE = 0, S_DELAY = 1, S_SOFT = 2, S_RUN = 3,
                 S_HICCUP = 4, S_RESET = 5, S_HIZ = 6;

  logic clk, rst_n, en_req, ms_tick, bat_low, out_uv, out_ov, cc_mode;
  logic [1:0] dly_sel;
  logic [SSW-1:0] ss_ms;
  logic boost_en, ss_en, hiz, cc_flag;
  logic [2:0] state_o;

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;

  boost_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .en_req(en_req), .ms_tick(ms_tick),
    .bat_low(bat_low), .out_uv(out_uv), .out_ov(out_ov), .cc_mode(cc_mode),
    .dly_sel(dly_sel), .ss_ms(ss_ms), .boost_en(boost_en), .ss_en(ss_en),
    .hiz(hiz), .cc_flag(cc_flag), .state_o(state_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model built from the requirements
  int m_state, m_cnt, m_ov;

  function automatic int dly_of(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 10;
      2'd2: return 100;
      default: return 1000;
    endcase
  endfunction

  function automatic int next_of(input int st, input int cnt, input int ovc);
    bit trip = (ovc >= 100);
    if (!en_req) return S_IDLE;
    case (st)
      S_IDLE:   return bat_low ? S_IDLE : S_DELAY;
      S_DELAY:  return bat_low ? S_RESET : (cnt >= dly_of(dly_sel) ? S_SOFT : S_DELAY);
      S_SOFT:   return bat_low ? S_RESET : trip ? S_HIZ : (cnt >= int'(ss_ms) ? S_RUN : S_SOFT);
      S_RUN:    return bat_low ? S_RESET : trip ? S_HIZ : out_uv ? S_HICCUP : S_RUN;
      S_HICCUP: return (cnt >= 3000) ? S_RESET : S_HICCUP;
      S_RESET:  return bat_low ? S_RESET : S_DELAY;
      default:  return S_HIZ;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = S_IDLE; m_cnt = 0; m_ov = 0;
    end else begin
      int ns;
      ns = next_of(m_state, m_cnt, m_ov);
      if (out_ov && (m_state == S_SOFT || m_state == S_RUN)) begin
        if (ms_tick && m_ov < 100) m_ov = m_ov + 1;
      end else m_ov = 0;
      if (ns != m_state) m_cnt = 0;
      else if (ms_tick) m_cnt = m_cnt + 1;
      m_state = ns;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model (R2 R3 R4 R5 R7 R8 R10 R11)
  always @(posedge clk) begin
    if (cmp_on) begin
      #(CLK_PERIOD/4);
      chk("model state R2", int'(state_o), m_state);
      chk("model boost R3", int'(boost_en), int'(m_state == S_SOFT || m_state == S_RUN));
      chk("model hiz R8", int'(hiz), int'(m_state == S_HIZ));
      chk("model cc R4", int'(cc_flag), int'(m_state == S_RUN && cc_mode));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bit ovb;
    rst_n = 1'b0; en_req = 0; ms_tick = 0; bat_low = 0; out_uv = 0;
    out_ov = 0; cc_mode = 0; dly_sel = 0; ss_ms = '0;
    step(3);
    chk("R1 state in reset", int'(state_o), S_IDLE);
    rst_n = 1'b1;
    step(1);
    cmp_on = 1;
    chk("R1 state", int'(state_o), S_IDLE);
    chk("R1 outputs", int'({boost_en, ss_en, hiz, cc_flag}), 0);

    // Start sequence, delay code 01 -> 10 ticks
    ms_tick = 1; ss_ms = 8'd5; dly_sel = 2'b01; cc_mode = 1; en_req = 1;
    step(11); chk("R2 still delay", int'(state_o), S_DELAY);
    step(1);  chk("R2 to soft", int'(state_o), S_SOFT);
    chk("R3 soft enables", int'({boost_en, ss_en}), 3);
    step(5);  chk("R3 still soft", int'(state_o), S_SOFT);
    step(1);  chk("R3 to run", int'(state_o), S_RUN);
    chk("R4 run cc", int'({boost_en, ss_en, cc_flag}), 5);
    cc_mode = 0; step(1);
    chk("R4 run cv", int'({state_o == 3'd3, cc_flag}), 2);

    // Undervoltage hiccup, with ticks paused
    out_uv = 1; step(1);
    chk("R5 to hiccup", int'(state_o), S_HICCUP);
    chk("R5 boost off", int'(boost_en), 0);
    out_uv = 0; ms_tick = 0; step(50);
    chk("R11 no tick holds", int'(state_o), S_HICCUP);
    ms_tick = 1; step(3000);
    chk("R5 hiccup length", int'(state_o), S_HICCUP);
    step(1); chk("R5 to reset", int'(state_o), S_RESET);
    step(1); chk("R6 restart", int'(state_o), S_DELAY);
    step(11); step(6); chk("R6 back in run", int'(state_o), S_RUN);
    out_uv = 1; step(1); out_uv = 0;
    chk("R6 retry hiccup", int'(state_o), S_HICCUP);
    step(3001); chk("R6 second reset", int'(state_o), S_RESET);

    // Battery cutoff
    bat_low = 1; step(3);
    chk("R7 held in reset", int'(state_o), S_RESET);
    bat_low = 0; step(1); chk("R7 release", int'(state_o), S_DELAY);
    step(11); chk("R7 soft", int'(state_o), S_SOFT);
    bat_low = 1; step(1);
    chk("R7 soft to reset", int'({state_o, boost_en}), (S_RESET << 1));
    bat_low = 0; step(1); step(11); step(6);
    chk("R7 run again", int'(state_o), S_RUN);

    // Overvoltage glitch then full trip
    out_ov = 1; step(60); out_ov = 0; step(1); out_ov = 1; step(60);
    chk("R9 glitch no trip", int'(state_o), S_RUN);
    step(40); chk("R8 window not done", int'(state_o), S_RUN);
    step(1);
    chk("R8 hiz entered", int'({hiz, boost_en}), 2);
    out_ov = 0; step(5); chk("R8 hiz latched", int'(state_o), S_HIZ);
    en_req = 0; step(1);
    chk("R10 hiz to idle", int'({state_o, hiz}), 0);

    // Other delay codes
    dly_sel = 2'b00; en_req = 1; step(1);
    chk("R2 code00 delay", int'(state_o), S_DELAY);
    step(1); chk("R2 code00 soft", int'(state_o), S_SOFT);
    en_req = 0; step(1); chk("R10 soft to idle", int'(state_o), S_IDLE);
    dly_sel = 2'b10; en_req = 1; step(101);
    chk("R2 code10 delay", int'(state_o), S_DELAY);
    step(1); chk("R2 code10 soft", int'(state_o), S_SOFT);
    en_req = 0; step(1);
    dly_sel = 2'b11; en_req = 1; step(1001);
    chk("R2 code11 delay", int'(state_o), S_DELAY);
    step(1); chk("R2 code11 soft", int'(state_o), S_SOFT);
    en_req = 0; step(1);
    dly_sel = 2'b00; ss_ms = '0; en_req = 1; step(2);
    chk("R3 zero soft", int'(state_o), S_SOFT);
    step(1); chk("R3 zero soft run", int'(state_o), S_RUN);

    // Constrained random phase against the model
    void'($urandom(32'h1d2c3b4a));
    ovb = 0;
    for (int i = 0; i < 20000; i++) begin
      en_req  = ($urandom % 400) != 0;
      bat_low = ($urandom % 300) == 0;
      out_uv  = ($urandom % 200) == 0;
      if (($urandom % 150) == 0) ovb = !ovb;
      out_ov  = ovb && (($urandom % 40) != 0);
      ms_tick = $urandom % 2;
      cc_mode = $urandom % 2;
      if (($urandom % 500) == 0) dly_sel = 2'($urandom % 2);
      if (($urandom % 500) == 0) ss_ms = SSW'($urandom % 16);
      step(1);
    end
    cmp_on = 0;
    step(1);
    finish_run();
  end

endmodule